// File: doc/BRIEF.md
# Keccak Sponge Absorb/Squeeze Controller

This block puts a Keccak-f permutation core inside a sponge construction. The state is `25*LANE_W` bits wide. The rate part is `RATE_BYTES*8` bits and sits at the low end of the state. The remaining bits form the capacity and are never exposed. Message blocks arrive on a valid/ready stream. Each beat carries one full rate-sized block, a flag marking the final block, and a byte count that applies only to that final block.

For each block the controller:
1. Pads the block if it is the final one.
2. XORs it into the rate part of the state.
3. Starts the permutation.

A final block with no room left for padding is followed by an extra padding-only block, which the controller adds on its own. Once the final block has been absorbed, the controller presents the rate part of the state on an output stream. Each time the consumer takes a word and asks for more, the state is permuted again and the next word is presented. The output can therefore be as long as needed. When the consumer takes a word without asking for more, the state is cleared and the block waits for a new message.

The permutation runs one round per clock in a separate core. That core also holds the only copy of the state. The round constants and rotation offsets are derived at elaboration from the lane width.

Top module: `keccak_sponge`

## Requirements
- R1: After synchronous reset, `msg_ready` is 1, `sq_valid` is 0 and the state is all zero.
- R2: Block byte i occupies bits [8i+7:8i] of `msg_data` and is XORed into state bits [8i+7:8i]. Lane (x,y) of the state is bits [64(x+5y)+63 : 64(x+5y)], least significant byte first. `sq_data` byte i is state byte i.
- R3: In a final block carrying n < RATE_BYTES bytes, byte n becomes 0x01 and 0x80 is ORed into byte RATE_BYTES-1. When n = RATE_BYTES-1 the single padding byte is 0x81.
- R4: Bytes at index n and above in a final block are ignored. `msg_nbytes` is ignored on non-final blocks, which are always absorbed whole.
- R5: Messages of any number of blocks are absorbed one block per permutation, in arrival order.
- R6: `msg_ready` is 0 from the cycle after a block is accepted until the block returns to the absorb phase. `msg_ready` and `sq_valid` are never 1 together.
- R7: `sq_valid` rises only after a permutation finishes. While `sq_valid` is 1 and `sq_ready` is 0, `sq_valid` stays 1 and `sq_data` stays unchanged.
- R8: An output handshake with `sq_more`=1 permutes the state again and then presents the next rate word.
- R9: An output handshake with `sq_more`=0 clears the state and re-enters the absorb phase on the next cycle. The following message is hashed from a zero state.
- R10: A final block with `msg_nbytes` greater than RATE_BYTES is treated as a full final block.
- R11: With LANE_W=64 and RATE_BYTES=136:
  - the first 32 output bytes for the empty message are c5d2460186f7233c927e7db2dcc703c0e500b653ca82273b7bfad8045d85a470;
  - for the 43-byte pangram "The quick brown fox jumps over the lazy dog" they are 4d741b6f1eb29cb2a9b9911c82f56fa8d73b04959d3d9d222895df6c0b28aa15.
- R12: The permutation runs NR = 12 + 2*log2(LANE_W) rounds, one per cycle. `sq_valid` rises NR+1 cycles after the final block or a more-request is accepted. The delay is 2*(NR+1) cycles when an extra padding block is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | Message block offered |
| msg_ready | output | 1 | Controller accepts a block this cycle |
| msg_data | input | RATE_BYTES*8 | Message block, byte i at bits [8i+7:8i] |
| msg_last | input | 1 | This block is the final block of the message |
| msg_nbytes | input | $clog2(RATE_BYTES+1) | Valid byte count of the final block |
| sq_valid | output | 1 | Output word available |
| sq_ready | input | 1 | Consumer takes the output word |
| sq_more | input | 1 | Sampled with the output handshake: 1 requests another word |
| sq_data | output | RATE_BYTES*8 | Rate part of the state |

## Verification
Message lengths are swept across the low range, every length around the first block boundary, and the second and third boundaries. This separates three cases: in-block padding, the merged 0x81 padding byte, and the extra padding block, each with its own latency. Two known answers pin the byte and lane ordering against an independent arithmetic model in the bench. That model is then used for all other lengths and for multi-word squeezes. Filler bytes of 0x00 and 0xFF beyond the count show that masking works. Held-off output handshakes and an oversized byte count exercise backpressure and count clamping.

// File: rtl/keccak_sponge_pkg.sv
`timescale 1ns/1ps
// Package: shared phase type and elaboration-time constant functions for the
// Keccak permutation (round constants, rotation offsets).
package keccak_sponge_pkg;

    typedef enum logic [1:0] {
        PH_ABSORB = 2'd0,
        PH_RUN    = 2'd1,
        PH_OUT    = 2'd2
    } sponge_phase_e;

    // Rotation amount for lane (x,y), walked along the (x,y) -> (y,2x+3y) orbit.
    function automatic int rho_offset(input int x, input int y, input int w);
        int cx;
        int cy;
        int nx;
        int res;
        cx  = 1;
        cy  = 0;
        res = 0;
        for (int t = 0; t < 24; t++) begin
            if (cx == x && cy == y) res = ((t + 1) * (t + 2) / 2) % w;
            nx = cy;
            cy = (2 * cx + 3 * cy) % 5;
            cx = nx;
        end
        return res;
    endfunction

    // 64-bit round constant of round rnd from the degree-8 LFSR (taps 0x71).
    function automatic logic [63:0] round_const(input int rnd);
        logic [7:0]  s;
        logic [63:0] v;
        s = 8'h01;
        v = '0;
        for (int k = 0; k < 7 * rnd; k++)
            s = s[7] ? ((s << 1) ^ 8'h71) : (s << 1);
        for (int j = 0; j < 7; j++) begin
            if (s[0]) v[(1 << j) - 1] = 1'b1;
            s = s[7] ? ((s << 1) ^ 8'h71) : (s << 1);
        end
        return v;
    endfunction

endpackage

// File: rtl/keccak_round.sv
`timescale 1ns/1ps
// Module: keccak_round
// One combinational Keccak-f round (theta, rho, pi, chi, iota) on a state of
// 25 lanes of LANE_W bits. Lane (x,y) sits at bits [LANE_W*(x+5y) +: LANE_W].
// Assumes LANE_W is a power of two between 2 and 64.
module keccak_round #(
    parameter int LANE_W = 64
) (
    input  logic [25*LANE_W-1:0] state_in,
    input  logic [LANE_W-1:0]    rc,
    output logic [25*LANE_W-1:0] state_out
);

    // Left rotation by n (0 <= n < LANE_W).
    function automatic logic [LANE_W-1:0] rotl(input logic [LANE_W-1:0] v, input int n);
        if (n == 0) return v;
        return (v << n) | (v >> (LANE_W - n));
    endfunction

    logic [LANE_W-1:0] lane_a [25];
    logic [LANE_W-1:0] lane_t [25];
    logic [LANE_W-1:0] lane_b [25];
    logic [LANE_W-1:0] par    [5];
    logic [LANE_W-1:0] dmix   [5];

    genvar gi, gx, gy;

    // Unpack the flat state into lanes.
    for (gi = 0; gi < 25; gi++) begin : g_unpack
        assign lane_a[gi] = state_in[gi*LANE_W +: LANE_W];
    end

    // Theta: column parities and their mixing term.
    for (gx = 0; gx < 5; gx++) begin : g_par
        assign par[gx]  = lane_a[gx] ^ lane_a[gx+5] ^ lane_a[gx+10] ^ lane_a[gx+15] ^ lane_a[gx+20];
        assign dmix[gx] = par[(gx+4)%5] ^ rotl(par[(gx+1)%5], 1 % LANE_W);
    end

    for (gi = 0; gi < 25; gi++) begin : g_theta
        assign lane_t[gi] = lane_a[gi] ^ dmix[gi%5];
    end

    // Rho and pi: rotate each lane, move (x,y) to (y, 2x+3y).
    for (gx = 0; gx < 5; gx++) begin : g_rpx
        for (gy = 0; gy < 5; gy++) begin : g_rpy
            localparam int ROT = keccak_sponge_pkg::rho_offset(gx, gy, LANE_W);
            assign lane_b[gy + 5*((2*gx + 3*gy) % 5)] = rotl(lane_t[gx + 5*gy], ROT);
        end
    end

    // Chi along rows, iota on lane (0,0).
    for (gx = 0; gx < 5; gx++) begin : g_chx
        for (gy = 0; gy < 5; gy++) begin : g_chy
            localparam int IDX = gx + 5*gy;
            if (IDX == 0) begin : g_iota
                assign state_out[IDX*LANE_W +: LANE_W] =
                    lane_b[IDX] ^ (~lane_b[(gx+1)%5 + 5*gy] & lane_b[(gx+2)%5 + 5*gy]) ^ rc;
            end else begin : g_plain
                assign state_out[IDX*LANE_W +: LANE_W] =
                    lane_b[IDX] ^ (~lane_b[(gx+1)%5 + 5*gy] & lane_b[(gx+2)%5 + 5*gy]);
            end
        end
    end

endmodule

// File: rtl/keccak_perm.sv
`timescale 1ns/1ps
// Module: keccak_perm
// Iterative Keccak-f core, one round per clock. It owns the sponge state
// register: load_en overwrites it, start begins NUM_ROUNDS rounds, and done
// pulses one cycle after the last round. Assumes the user never loads or
// starts while busy.
module keccak_perm #(
    parameter int LANE_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [25*LANE_W-1:0] load_state,
    input  logic                 start,
    output logic [25*LANE_W-1:0] state_q,
    output logic                 busy,
    output logic                 done
);

    localparam int STATE_W    = 25 * LANE_W;
    localparam int LOG_W      = $clog2(LANE_W);
    localparam int NUM_ROUNDS = 12 + 2 * LOG_W;
    localparam int RND_W      = $clog2(NUM_ROUNDS);

    logic [RND_W-1:0]   rnd;
    logic [LANE_W-1:0]  rc_tab [NUM_ROUNDS];
    logic [STATE_W-1:0] round_out;

    genvar gr;
    // Round constants computed at elaboration and truncated to the lane width.
    for (gr = 0; gr < NUM_ROUNDS; gr++) begin : g_rc
        localparam logic [63:0] RC_FULL = keccak_sponge_pkg::round_const(gr);
        assign rc_tab[gr] = RC_FULL[LANE_W-1:0];
    end

    keccak_round #(.LANE_W(LANE_W)) u_round (
        .state_in  (state_q),
        .rc        (rc_tab[rnd]),
        .state_out (round_out)
    );

    // State register, round counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            busy    <= 1'b0;
            rnd     <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load_en) state_q <= load_state;
            if (start) begin
                busy <= 1'b1;
                rnd  <= '0;
            end else if (busy) begin
                state_q <= round_out;
                if (rnd == RND_W'(NUM_ROUNDS - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    rnd <= rnd + 1'b1;
                end
            end
        end
    end

    // R12: the state is never rewritten from outside during rounds.
    assert_no_load_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load_en && !start);
    // R12: completion follows a busy period and ends it.
    assert_done_after_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));
    // R12: a start always opens a busy period.
    assert_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

endmodule

// File: rtl/sponge_pad.sv
`timescale 1ns/1ps
// Module: sponge_pad
// Combinational block formatter. Non-final blocks pass through unchanged.
// A final block keeps bytes below nbytes, puts 0x01 at byte nbytes and ORs
// 0x80 into the last byte when nbytes < RATE_BYTES. Assumes
// nbytes <= RATE_BYTES; a padding-only block is nbytes = 0 with last = 1.
module sponge_pad #(
    parameter int RATE_BYTES = 136,
    parameter int CNT_W      = $clog2(RATE_BYTES + 1)
) (
    input  logic [RATE_BYTES*8-1:0] data,
    input  logic [CNT_W-1:0]        nbytes,
    input  logic                    last,
    output logic [RATE_BYTES*8-1:0] block
);

    genvar gb;
    for (gb = 0; gb < RATE_BYTES; gb++) begin : g_byte
        localparam logic [CNT_W-1:0] IDX = CNT_W'(gb);
        logic [7:0] pb;
        // Select data, start marker or zero, then add the end marker.
        always_comb begin
            if (!last || IDX < nbytes) pb = data[gb*8 +: 8];
            else if (IDX == nbytes)    pb = 8'h01;
            else                       pb = 8'h00;
            if (last && gb == RATE_BYTES - 1 && nbytes < CNT_W'(RATE_BYTES))
                pb = pb | 8'h80;
        end
        assign block[gb*8 +: 8] = pb;
    end

endmodule

// File: rtl/keccak_sponge.sv
`timescale 1ns/1ps
// Module: keccak_sponge
// Sponge controller around keccak_perm. It absorbs rate-sized blocks, pads
// the final one (adding a padding-only block when the final block is full),
// then squeezes rate words, permuting again whenever more output is asked
// for. It clears the state when the consumer closes the output.
// Assumes RATE_BYTES*8 < 25*LANE_W.
module keccak_sponge #(
    parameter int LANE_W     = 64,
    parameter int RATE_BYTES = 136
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 msg_valid,
    output logic                                 msg_ready,
    input  logic [RATE_BYTES*8-1:0]              msg_data,
    input  logic                                 msg_last,
    input  logic [$clog2(RATE_BYTES+1)-1:0]      msg_nbytes,
    output logic                                 sq_valid,
    input  logic                                 sq_ready,
    input  logic                                 sq_more,
    output logic [RATE_BYTES*8-1:0]              sq_data
);

    import keccak_sponge_pkg::*;

    localparam int STATE_W = 25 * LANE_W;
    localparam int RATE_W  = RATE_BYTES * 8;
    localparam int CAP_W   = STATE_W - RATE_W;
    localparam int CNT_W   = $clog2(RATE_BYTES + 1);

    sponge_phase_e      phase;
    logic               pend_extra;
    logic               pend_out;

    logic [CNT_W-1:0]   n_eff;
    logic [RATE_W-1:0]  pad_data;
    logic [CNT_W-1:0]   pad_n;
    logic               pad_last;
    logic [RATE_W-1:0]  pad_block;

    logic               accept;
    logic               extra_go;
    logic               sq_fire;
    logic               load_clear;
    logic               perm_load;
    logic               perm_start;
    logic [STATE_W-1:0] perm_load_val;
    logic [STATE_W-1:0] perm_state;
    logic               perm_busy;
    logic               perm_done;

    // Clamp an oversized count to a full block.
    assign n_eff = (msg_nbytes > CNT_W'(RATE_BYTES)) ? CNT_W'(RATE_BYTES) : msg_nbytes;

    // The padding-only block shares the formatter: no data, zero count, final.
    always_comb begin
        pad_data = pend_extra ? '0 : msg_data;
        pad_n    = pend_extra ? '0 : n_eff;
        pad_last = pend_extra ? 1'b1 : msg_last;
    end

    sponge_pad #(.RATE_BYTES(RATE_BYTES), .CNT_W(CNT_W)) u_pad (
        .data   (pad_data),
        .nbytes (pad_n),
        .last   (pad_last),
        .block  (pad_block)
    );

    // Handshake and permutation control decode.
    always_comb begin
        accept        = (phase == PH_ABSORB) && msg_valid;
        extra_go      = (phase == PH_RUN) && perm_done && pend_extra;
        sq_fire       = (phase == PH_OUT) && sq_ready;
        load_clear    = sq_fire && !sq_more;
        perm_load     = accept || extra_go || load_clear;
        perm_start    = accept || extra_go || (sq_fire && sq_more);
        perm_load_val = load_clear ? '0 : (perm_state ^ {{CAP_W{1'b0}}, pad_block});
    end

    keccak_perm #(.LANE_W(LANE_W)) u_perm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (perm_load),
        .load_state (perm_load_val),
        .start      (perm_start),
        .state_q    (perm_state),
        .busy       (perm_busy),
        .done       (perm_done)
    );

    // Phase sequencing across absorb, permutation and squeeze.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_ABSORB;
            pend_extra <= 1'b0;
            pend_out   <= 1'b0;
        end else begin
            unique case (phase)
                PH_ABSORB: if (accept) begin
                    phase      <= PH_RUN;
                    pend_extra <= msg_last && (n_eff == CNT_W'(RATE_BYTES));
                    pend_out   <= msg_last;
                end
                PH_RUN: if (perm_done) begin
                    if (pend_extra)    pend_extra <= 1'b0;
                    else if (pend_out) phase      <= PH_OUT;
                    else               phase      <= PH_ABSORB;
                end
                PH_OUT: if (sq_fire) begin
                    if (sq_more) phase <= PH_RUN;
                    else begin
                        phase    <= PH_ABSORB;
                        pend_out <= 1'b0;
                    end
                end
                default: phase <= PH_ABSORB;
            endcase
        end
    end

    assign msg_ready = (phase == PH_ABSORB);
    assign sq_valid  = (phase == PH_OUT);
    assign sq_data   = perm_state[RATE_W-1:0];

    // R6: no block is accepted while the permutation runs.
    assert_ready_low_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        perm_busy |-> !msg_ready);
    // R6: absorb and squeeze phases never overlap at the ports.
    assert_phase_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(msg_ready && sq_valid));
    // R7: an unaccepted output word holds.
    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid && !sq_ready |=> sq_valid && $stable(sq_data));
    // R7: output appears only right after a finished permutation.
    assert_valid_after_perm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sq_valid) |-> $past(perm_done));
    // R9: closing the output clears the state and reopens the input.
    assert_clear_on_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid && sq_ready && !sq_more |=> (perm_state == '0) && msg_ready);

endmodule

// File: tb/keccak_sponge_tb.sv
`timescale 1ns/1ps
module keccak_sponge_tb;

    localparam int LW = 64;
    localparam int RB = 136;
    localparam int RW = RB * 8;
    localparam int NR = 24;
    localparam int CW = $clog2(RB + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          msg_valid = 1'b0;
    logic          msg_ready;
    logic [RW-1:0] msg_data = '0;
    logic          msg_last = 1'b0;
    logic [CW-1:0] msg_nbytes = '0;
    logic          sq_valid;
    logic          sq_ready = 1'b0;
    logic          sq_more = 1'b0;
    logic [RW-1:0] sq_data;

    always #5 clk = ~clk;

    keccak_sponge #(.LANE_W(LW), .RATE_BYTES(RB)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data),
        .msg_last(msg_last), .msg_nbytes(msg_nbytes),
        .sq_valid(sq_valid), .sq_ready(sq_ready), .sq_more(sq_more), .sq_data(sq_data)
    );

    int            n_chk = 0;
    int            n_bad = 0;
    logic [7:0]    mb [0:699];
    logic [63:0]   ms [25];
    int            rho_t [25];
    logic [63:0]   rc_t [NR];
    logic [RW-1:0] exp_w [0:3];
    logic [RW-1:0] got0;

    task automatic chk_int(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic chk_vec(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Textbook LFSR bit rc(t).
    function automatic bit lfsr_bit(input int t);
        logic [7:0] r;
        logic [8:0] r9;
        if (t % 255 == 0) return 1'b1;
        r = 8'h01;
        for (int i = 1; i <= t % 255; i++) begin
            r9 = {r, 1'b0};
            r9[0] ^= r9[8]; r9[4] ^= r9[8]; r9[5] ^= r9[8]; r9[6] ^= r9[8];
            r = r9[7:0];
        end
        return r[0];
    endfunction

    function automatic logic [63:0] rol(input logic [63:0] v, input int n);
        return (n == 0) ? v : ((v << n) | (v >> (64 - n)));
    endfunction

    function automatic logic [255:0] brev(input logic [255:0] v);
        logic [255:0] r;
        for (int i = 0; i < 32; i++) r[8*i +: 8] = v[8*(31-i) +: 8];
        return r;
    endfunction

    task automatic init_tables();
        int x, y, nx;
        for (int i = 0; i < NR; i++) begin
            rc_t[i] = '0;
            for (int j = 0; j < 7; j++) if (lfsr_bit(j + 7*i)) rc_t[i][(1 << j) - 1] = 1'b1;
        end
        rho_t[0] = 0;
        x = 1; y = 0;
        for (int t = 0; t < 24; t++) begin
            rho_t[x + 5*y] = ((t + 1) * (t + 2) / 2) % 64;
            nx = y; y = (2*x + 3*y) % 5; x = nx;
        end
    endtask

    task automatic model_perm();
        logic [63:0] c [5];
        logic [63:0] d [5];
        logic [63:0] b [25];
        for (int r = 0; r < NR; r++) begin
            for (int x = 0; x < 5; x++) c[x] = ms[x] ^ ms[x+5] ^ ms[x+10] ^ ms[x+15] ^ ms[x+20];
            for (int x = 0; x < 5; x++) d[x] = c[(x+4)%5] ^ rol(c[(x+1)%5], 1);
            for (int i = 0; i < 25; i++) ms[i] ^= d[i%5];
            for (int x = 0; x < 5; x++)
                for (int y = 0; y < 5; y++)
                    b[y + 5*((2*x + 3*y) % 5)] = rol(ms[x + 5*y], rho_t[x + 5*y]);
            for (int x = 0; x < 5; x++)
                for (int y = 0; y < 5; y++)
                    ms[x + 5*y] = b[x + 5*y] ^ (~b[(x+1)%5 + 5*y] & b[(x+2)%5 + 5*y]);
            ms[0] ^= rc_t[r];
        end
    endtask

    // Byte-stream sponge model: pad10*1 over bytes, nw output words.
    task automatic model_run(input int len, input int nw);
        int nblk;
        logic [7:0] pbyte;
        for (int i = 0; i < 25; i++) ms[i] = '0;
        nblk = len / RB + 1;
        for (int b = 0; b < nblk; b++) begin
            for (int j = 0; j < RB; j++) begin
                int p;
                p = b*RB + j;
                pbyte = (p < len) ? mb[p] : 8'h00;
                if (p == len) pbyte ^= 8'h01;
                if (p == nblk*RB - 1) pbyte ^= 8'h80;
                ms[j/8][8*(j%8) +: 8] ^= pbyte;
            end
            model_perm();
        end
        for (int k = 0; k < nw; k++) begin
            if (k > 0) model_perm();
            for (int j = 0; j < RB; j++) exp_w[k][8*j +: 8] = ms[j/8][8*(j%8) +: 8];
        end
    endtask

    // Drive a message; bytes beyond the count carry junk. Called at a negedge.
    task automatic send(input int len, input logic [7:0] junk, input int nb_force);
        int nblk;
        int n;
        nblk = (len == 0) ? 1 : (len + RB - 1) / RB;
        for (int b = 0; b < nblk; b++) begin
            msg_last = (b == nblk - 1);
            n = msg_last ? len - b*RB : RB;
            for (int j = 0; j < RB; j++) msg_data[8*j +: 8] = (j < n) ? mb[b*RB + j] : junk;
            msg_nbytes = msg_last ? ((nb_force >= 0) ? CW'(nb_force) : CW'(n)) : CW'(0);
            msg_valid = 1'b1;
            while (!msg_ready) @(negedge clk);
            @(negedge clk);
            msg_valid = 1'b0;
        end
    endtask

    task automatic wait_out(output int k, output bit ready_seen);
        k = 0;
        ready_seen = 1'b0;
        while (!sq_valid && k < 400) begin
            if (msg_ready) ready_seen = 1'b1;
            @(negedge clk);
            k++;
        end
    endtask

    task automatic run_case(input string name, input int len, input logic [7:0] junk,
                            input int nw, input int nb_force, input bit hold);
        int lat;
        int exp_lat;
        bit rs;
        logic [RW-1:0] first;
        bit full_final;
        model_run(len, nw);
        full_final = (nb_force > RB) || (len > 0 && len % RB == 0);
        send(len, junk, nb_force);
        for (int k = 0; k < nw; k++) begin
            wait_out(lat, rs);
            exp_lat = (k == 0 && full_final) ? 2*(NR+1) : NR + 1;
            chk_int(lat == exp_lat, {"R12 latency ", name}, lat, exp_lat);
            chk_int(!rs, {"R6 ready low ", name}, int'(rs), 0);
            first = sq_data;
            if (k == 0) got0 = sq_data;
            if (hold) begin
                repeat (6) @(negedge clk);
                chk_int(sq_valid, {"R7 valid held ", name}, int'(sq_valid), 1);
                chk_vec({"R7 data held ", name}, sq_data, first);
            end
            if (k == 0) chk_vec({"R2 R3 word0 ", name}, sq_data, exp_w[0]);
            else        chk_vec({"R8 next word ", name}, sq_data, exp_w[k]);
            sq_ready = 1'b1;
            sq_more  = (k < nw - 1);
            @(negedge clk);
            sq_ready = 1'b0;
            sq_more  = 1'b0;
        end
        chk_int(msg_ready && !sq_valid, {"R9 reopen ", name}, int'({msg_ready, sq_valid}), 2);
    endtask

    task automatic fill_pattern(input int len, input int seed);
        for (int i = 0; i < len; i++) mb[i] = 8'((i * 37 + seed * 11 + 3) & 8'hff);
    endtask

    initial begin
        string fox;
        init_tables();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_int(msg_ready, "R1 msg_ready after reset", int'(msg_ready), 1);
        chk_int(!sq_valid, "R1 sq_valid after reset", int'(sq_valid), 0);

        // R11 known answers; empty also exercises R3 with n = 0.
        run_case("empty", 0, 8'h5a, 1, -1, 1'b0);
        chk_int(brev(got0[255:0]) == 256'hc5d2460186f7233c927e7db2dcc703c0e500b653ca82273b7bfad8045d85a470,
                "R11 empty digest", 0, 1);
        fox = "The quick brown fox jumps over the lazy dog";
        for (int i = 0; i < fox.len(); i++) mb[i] = fox[i];
        run_case("pangram", fox.len(), 8'h00, 1, -1, 1'b0);
        chk_int(brev(got0[255:0]) == 256'h4d741b6f1eb29cb2a9b9911c82f56fa8d73b04959d3d9d222895df6c0b28aa15,
                "R11 pangram digest", 0, 1);

        // R3 R5: sweep lengths across the first three block boundaries.
        for (int len = 1; len <= 6; len++) begin
            fill_pattern(len, len);
            run_case($sformatf("len%0d", len), len, 8'hc3, 1, -1, 1'b0);
        end
        for (int len = 132; len <= 140; len++) begin
            fill_pattern(len, len);
            run_case($sformatf("len%0d", len), len, 8'h3c, 1, -1, 1'b0);
        end
        foreach (mb[i]) if (i < 0) mb[i] = 0;
        for (int len = 271; len <= 273; len++) begin
            fill_pattern(len, len);
            run_case($sformatf("R5 len%0d", len), len, 8'h96, 1, -1, 1'b0);
        end
        fill_pattern(408, 9);
        run_case("R5 len408", 408, 8'h11, 1, -1, 1'b0);

        // R4: filler beyond the count must not matter.
        fill_pattern(77, 4);
        run_case("R4 junk00", 77, 8'h00, 1, -1, 1'b0);
        run_case("R4 junkff", 77, 8'hff, 1, -1, 1'b0);

        // R8: multi-word squeeze; R7: held-off handshakes.
        fill_pattern(150, 2);
        run_case("R8 four words", 150, 8'h00, 4, -1, 1'b0);
        fill_pattern(10, 5);
        run_case("R7 backpressure", 10, 8'h00, 2, -1, 1'b1);

        // R10: oversized count acts as a full final block.
        fill_pattern(136, 6);
        run_case("R10 count 200", 136, 8'h00, 1, 200, 1'b0);

        // R9: a message right after another starts from a zero state.
        fill_pattern(20, 8);
        run_case("R9 first", 20, 8'h00, 1, -1, 1'b0);
        run_case("R9 repeat", 20, 8'h00, 1, -1, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (120000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule